// File: doc/BRIEF.md
# PCI Power State Controller

This block follows the PCI power-management state of a network device across five states: fully off, D0 uninitialised, D0 active, D3 hot and D3 cold. It watches the PCI reset line, the main power-good flag and the auxiliary-power flag. All three are asynchronous and pass through two-flop synchronizers. It also watches the two-bit power-state field that the host writes, which is already in the local clock domain. From these inputs it decides the current state and drives the side effects of that state. The side effects are the PHY reset and power-down request, the clock enable for the PLL and its derived clocks, the memory/IO decode enable, a one-shot reset pulse when the device leaves D3 hot, and an active-low PME output.

Two things make the block more than a lookup table. When main power fails, the next state depends on whether auxiliary power is still present. When the device enters D3 hot, the PHY is kept running only if PME is enabled, so that it can still detect wake events.

Top module: `pci_pwr_fsm`

## Requirements
- R1: While `rst_n` is low and after its release, `pwr_state` is 0 (off). The state codes are off=0, D0-uninit=1, D0-active=2, D3-hot=3 and D3-cold=4. In the off state, `phy_pwrdn`=1, `clk_en`=0, `mem_io_en`=0, `d3_rst`=0, `pme_n`=1 and `pm_rb`=00.
- R2: `pci_rst_n_i`, `aux_det_i` and `pwr_good_i` each pass through two synchronizing flops. A change on one of them alters `pwr_state` at the third rising clock edge after the change, and not before.
- R3: The off state moves to D0-uninit when power-good and PCI reset (deasserted) are both high. D0-uninit moves to D0-active when `decode_en` is high.
- R4: D0-active moves to D3-hot in the cycle after `pm_field` changes from 00 to 11, provided PCI reset is deasserted and power-good is high. On this entry `phy_pwrdn` becomes 1 if `pme_en` is 0, and stays 0 if `pme_en` is 1.
- R5: D0-active moves to D0-uninit on a falling edge of the synchronized PCI reset while `pm_field` is 00.
- R6: A falling edge of power-good while auxiliary power is present moves D0-uninit, D0-active or D3-hot to D3-cold, and sets `phy_pwrdn` to 1.
- R7: From any state other than off, the block goes to off once power-good and auxiliary power are both low. This covers both supplies failing together.
- R8: `clk_en` is 1 only in D0-uninit and D0-active. `mem_io_en` is 1 only in D0-active. `pm_rb` reads 11 in D3-hot and D3-cold and reads 00 in every other state.
- R9: In D3-hot with `pme_en`=1, any of `wake_wol`, `wake_magic` or `wake_link` drives `pme_n` low from the next cycle. `pme_n` stays low until `pme_sts_clr` is pulsed or the state leaves D3-hot. With `pme_en`=0, wake inputs leave `pme_n` at 1.
- R10: D3-hot moves to D0-uninit in the cycle after `pm_field` changes from 11 to 00 with PCI reset deasserted and power-good high. `d3_rst` rises in that same cycle and stays high for exactly D3RST_CYC cycles (16 by default). `phy_pwrdn` becomes 0 whenever D0-uninit is entered.
- R11: D3-cold returns to D0-uninit when power-good is high again and PCI reset is deasserted.
- R12: The D3-hot to D3-cold move on a power-good fall takes place whatever the PCI reset level is.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous block reset |
| pci_rst_n_i | input | 1 | PCI reset line, active low, asynchronous |
| aux_det_i | input | 1 | Auxiliary supply present, asynchronous |
| pwr_good_i | input | 1 | Main supply good, asynchronous |
| pm_field | input | 2 | Power-state field written by the host (00=D0, 11=D3) |
| pme_en | input | 1 | PME enable bit |
| decode_en | input | 1 | Host enables memory or IO decode |
| wake_wol | input | 1 | Wake-on-LAN event |
| wake_magic | input | 1 | Magic packet event |
| wake_link | input | 1 | PHY link-status change event |
| pme_sts_clr | input | 1 | Host clears the PME status |
| pwr_state | output | 3 | Current state code |
| phy_pwrdn | output | 1 | PHY reset and power-down request |
| clk_en | output | 1 | PLL and derived clock enable |
| mem_io_en | output | 1 | Memory/IO access decode enable |
| d3_rst | output | 1 | Reset pulse on leaving D3-hot |
| pme_n | output | 1 | Active-low power-management event |
| pm_rb | output | 2 | Power-state readback |

## Verification
The bench runs the block through several paths:
- D3-hot entered with PME disabled and again with it enabled, which separates the two PHY policies and shows whether wake inputs are gated.
- Power-good failing with auxiliary power present, then auxiliary power failing afterwards, then both failing at once, which separates the D3-cold path from the off path.
- PCI reset asserted in D0-active and again in D3-hot, which shows that reset matters in the first state and is ignored in the second.
- Checks placed two and three edges after an asynchronous change, which pin the synchronizer latency.

A behavioural model is compared against every output on every clock. The length of the D3-exit pulse is counted separately.

// File: rtl/pci_pwr_fsm.sv
module pci_pwr_fsm #(
  parameter int D3RST_CYC = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pci_rst_n_i,
  input  logic       aux_det_i,
  input  logic       pwr_good_i,
  input  logic [1:0] pm_field,
  input  logic       pme_en,
  input  logic       decode_en,
  input  logic       wake_wol,
  input  logic       wake_magic,
  input  logic       wake_link,
  input  logic       pme_sts_clr,
  output logic [2:0] pwr_state,
  output logic       phy_pwrdn,
  output logic       clk_en,
  output logic       mem_io_en,
  output logic       d3_rst,
  output logic       pme_n,
  output logic [1:0] pm_rb
);
  localparam int CW = $clog2(D3RST_CYC + 1);

  typedef enum logic [2:0] {S_OFF = 3'd0, S_D0U = 3'd1, S_D0A = 3'd2,
                            S_D3H = 3'd3, S_D3C = 3'd4} st_t;

  st_t st, nxt;
  logic [1:0] rst_sy, aux_sy, pg_sy, pm_q;
  logic rst_q, pg_q, phy_off, pme_q;
  logic [CW-1:0] cnt;

  wire rst_ok  = rst_sy[1];
  wire aux_ok  = aux_sy[1];
  wire pg_ok   = pg_sy[1];
  wire pg_fall = pg_q & ~pg_ok;
  wire rst_fall = rst_q & ~rst_ok;
  wire to_d3   = (pm_q == 2'b00) && (pm_field == 2'b11);
  wire to_d0   = (pm_q == 2'b11) && (pm_field == 2'b00);
  wire wake    = wake_wol | wake_magic | wake_link;

  always_comb begin
    nxt = st;
    if (!pg_ok && !aux_ok && st != S_OFF) nxt = S_OFF;
    else begin
      case (st)
        S_OFF: if (pg_ok && rst_ok) nxt = S_D0U;
        S_D0U: if (pg_fall) nxt = S_D3C;
               else if (decode_en) nxt = S_D0A;
        S_D0A: if (pg_fall) nxt = S_D3C;
               else if (rst_fall && pm_field == 2'b00 && pg_ok) nxt = S_D0U;
               else if (to_d3 && rst_ok && pg_ok) nxt = S_D3H;
        S_D3H: if (pg_fall) nxt = S_D3C;
               else if (to_d0 && rst_ok && pg_ok) nxt = S_D0U;
        S_D3C: if (pg_ok && rst_ok) nxt = S_D0U;
        default: nxt = S_OFF;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sy  <= '0;
      aux_sy  <= '0;
      pg_sy   <= '0;
      rst_q   <= 1'b0;
      pg_q    <= 1'b0;
      pm_q    <= 2'b00;
      st      <= S_OFF;
      phy_off <= 1'b1;
      cnt     <= '0;
      pme_q   <= 1'b0;
    end else begin
      rst_sy <= {rst_sy[0], pci_rst_n_i};
      aux_sy <= {aux_sy[0], aux_det_i};
      pg_sy  <= {pg_sy[0], pwr_good_i};
      rst_q  <= rst_ok;
      pg_q   <= pg_ok;
      pm_q   <= pm_field;
      st     <= nxt;

      if (nxt == S_D0U && st != S_D0U) phy_off <= 1'b0;
      else if (st == S_D0A && nxt == S_D3H && !pme_en) phy_off <= 1'b1;
      else if (nxt == S_D3C && st != S_D3C) phy_off <= 1'b1;
      else if (nxt == S_OFF) phy_off <= 1'b1;

      if (st == S_D3H && nxt == S_D0U) cnt <= CW'(D3RST_CYC);
      else if (cnt != '0) cnt <= cnt - 1'b1;

      pme_q <= (st == S_D3H) && (nxt == S_D3H) && !pme_sts_clr &&
               (pme_q || (pme_en && wake));
    end
  end

  assign pwr_state = st;
  assign phy_pwrdn = phy_off;
  assign clk_en    = (st == S_D0U) || (st == S_D0A);
  assign mem_io_en = (st == S_D0A);
  assign d3_rst    = (cnt != '0);
  assign pme_n     = ~pme_q;
  assign pm_rb     = (st == S_D3H || st == S_D3C) ? 2'b11 : 2'b00;
endmodule

// File: rtl/pci_pwr_fsm_chk.sv
module pci_pwr_fsm_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [2:0] pwr_state,
  input logic       phy_pwrdn,
  input logic       clk_en,
  input logic       mem_io_en,
  input logic       d3_rst,
  input logic       pme_n,
  input logic       pme_en,
  input logic [1:0] pm_rb
);
  a_r8_d3hot_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_state == 3'd3 |-> !clk_en && !mem_io_en && pm_rb == 2'b11);

  a_r9_pme_only_d3hot: assert property (@(posedge clk) disable iff (!rst_n)
    !pme_n |-> pwr_state == 3'd3);

  a_r10_d3rst_on_exit: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(pwr_state) == 3'd3 && pwr_state == 3'd1) |-> d3_rst);

  a_r4_phy_policy: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(pwr_state) == 3'd2 && pwr_state == 3'd3) |-> phy_pwrdn == !$past(pme_en));

  a_r7_off_safe: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_state == 3'd0 |-> phy_pwrdn && pme_n && !clk_en && !mem_io_en);

  a_r6_cold_phy_off: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_state == 3'd4 |-> phy_pwrdn);
endmodule

bind pci_pwr_fsm pci_pwr_fsm_chk u_chk (.*);

// File: tb/pci_pwr_fsm_bench.sv
module pci_pwr_fsm_bench;
  logic clk = 1'b0, rst_n = 1'b0;
  logic pci_rst_n_i = 0, aux_det_i = 0, pwr_good_i = 0;
  logic [1:0] pm_field = 2'b00;
  logic pme_en = 0, decode_en = 0, wake_wol = 0, wake_magic = 0, wake_link = 0, pme_sts_clr = 0;
  logic [2:0] pwr_state;
  logic phy_pwrdn, clk_en, mem_io_en, d3_rst, pme_n;
  logic [1:0] pm_rb;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #10 clk = ~clk;

  pci_pwr_fsm u_pci_pwr_fsm (.*);

  // behavioural reference
  int rs1, rs2, as1, as2, ps1, ps2, rq, pq, pmq, mst, mnx, mphy, mcnt, mpme;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs1 = 0; rs2 = 0; as1 = 0; as2 = 0; ps1 = 0; ps2 = 0; rq = 0; pq = 0;
      pmq = 0; mst = 0; mphy = 1; mcnt = 0; mpme = 0;
    end else begin
      mnx = mst;
      if (ps2 == 0 && as2 == 0) mnx = 0;
      else if (mst == 0) begin if (ps2 == 1 && rs2 == 1) mnx = 1; end
      else if (pq == 1 && ps2 == 0) mnx = (mst == 4) ? 4 : 4;
      else if (mst == 1) begin if (decode_en) mnx = 2; end
      else if (mst == 2) begin
        if (rq == 1 && rs2 == 0 && pm_field == 0) mnx = 1;
        else if (pmq == 0 && pm_field == 3 && rs2 == 1) mnx = 3;
      end
      else if (mst == 3) begin if (pmq == 3 && pm_field == 0 && rs2 == 1) mnx = 1; end
      else if (mst == 4) begin if (ps2 == 1 && rs2 == 1) mnx = 1; end
      if (mnx == 1 && mst != 1) mphy = 0;
      else if (mst == 2 && mnx == 3 && !pme_en) mphy = 1;
      else if (mnx == 4 && mst != 4) mphy = 1;
      else if (mnx == 0) mphy = 1;
      if (mst == 3 && mnx == 1) mcnt = 16; else if (mcnt > 0) mcnt--;
      mpme = (mst == 3 && mnx == 3 && !pme_sts_clr &&
              (mpme == 1 || (pme_en && (wake_wol || wake_magic || wake_link)))) ? 1 : 0;
      rq = rs2; pq = ps2; rs2 = rs1; rs1 = pci_rst_n_i;
      as2 = as1; as1 = aux_det_i; ps2 = ps1; ps1 = pwr_good_i;
      pmq = pm_field; mst = mnx;
    end
  end

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (!done) begin
    chk("R1/state model", pwr_state, mst);
    chk("R4/R6/R10 phy model", phy_pwrdn, mphy);
    chk("R8 clk_en model", clk_en, (mst == 1 || mst == 2));
    chk("R8 decode model", mem_io_en, mst == 2);
    chk("R8 readback model", pm_rb, (mst == 3 || mst == 4) ? 3 : 0);
    chk("R10 d3_rst model", d3_rst, mcnt > 0);
    chk("R9 pme model", pme_n, !mpme);
  end

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #3000000;
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog expired");
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    step(3);
    chk("R1 reset state", pwr_state, 0);
    chk("R1 reset phy", phy_pwrdn, 1);
    chk("R1 reset pme", pme_n, 1);
    rst_n = 1;
    step(2);
    chk("R1 after release", pwr_state, 0);
    aux_det_i = 1; pwr_good_i = 1; pci_rst_n_i = 1;
    step(2);
    chk("R2 not yet", pwr_state, 0);
    step(1);
    chk("R3 off to D0U", pwr_state, 1);
    chk("R10 phy on at D0U", phy_pwrdn, 0);
    decode_en = 1; step(1); decode_en = 0;
    chk("R3 D0A", pwr_state, 2);
    chk("R8 clk in D0A", clk_en, 1);
    chk("R8 decode in D0A", mem_io_en, 1);
    // D3 hot without PME
    pme_en = 0; pm_field = 2'b11; step(1);
    chk("R4 enter D3H", pwr_state, 3);
    chk("R4 phy down pme off", phy_pwrdn, 1);
    chk("R8 clk off D3H", clk_en, 0);
    chk("R8 readback D3H", pm_rb, 3);
    wake_wol = 1; step(2); wake_wol = 0;
    chk("R9 wake gated", pme_n, 1);
    // exit D3 hot
    pm_field = 2'b00; step(1);
    chk("R10 to D0U", pwr_state, 1);
    begin
      int hi = 0;
      for (int i = 0; i < 24; i++) begin
        if (d3_rst) hi++;
        step(1);
      end
      chk("R10 pulse length", hi, 16);
    end
    chk("R10 phy released", phy_pwrdn, 0);
    decode_en = 1; step(1); decode_en = 0;
    // D3 hot with PME
    pme_en = 1; pm_field = 2'b11; step(1);
    chk("R4 enter D3H pme on", pwr_state, 3);
    chk("R4 phy kept", phy_pwrdn, 0);
    wake_magic = 1; step(1); wake_magic = 0;
    chk("R9 pme on magic", pme_n, 0);
    step(5);
    chk("R9 pme held", pme_n, 0);
    pme_sts_clr = 1; step(1); pme_sts_clr = 0;
    chk("R9 pme cleared", pme_n, 1);
    wake_link = 1; step(1); wake_link = 0;
    chk("R9 pme on link", pme_n, 0);
    pci_rst_n_i = 0; pwr_good_i = 0; step(3);
    chk("R12 D3H to D3C with reset low", pwr_state, 4);
    chk("R6 phy down D3C", phy_pwrdn, 1);
    chk("R9 pme dropped on exit", pme_n, 1);
    // restore
    pm_field = 2'b00; pwr_good_i = 1; pci_rst_n_i = 1; step(3);
    chk("R11 D3C to D0U", pwr_state, 1);
    decode_en = 1; step(1); decode_en = 0;
    pci_rst_n_i = 0; step(2);
    chk("R2 reset edge pending", pwr_state, 2);
    step(1);
    chk("R5 D0A to D0U", pwr_state, 1);
    pci_rst_n_i = 1; step(3);
    decode_en = 1; step(1); decode_en = 0;
    pwr_good_i = 0; step(3);
    chk("R6 D0A to D3C", pwr_state, 4);
    chk("R6 phy down", phy_pwrdn, 1);
    aux_det_i = 0; step(3);
    chk("R7 aux lost to off", pwr_state, 0);
    aux_det_i = 1; pwr_good_i = 1; step(3);
    decode_en = 1; step(1); decode_en = 0;
    chk("R3 D0A again", pwr_state, 2);
    aux_det_i = 0; pwr_good_i = 0; step(3);
    chk("R7 both lost to off", pwr_state, 0);
    chk("R7 phy down in off", phy_pwrdn, 1);
    step(2);
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule